// File: doc/BRIEF.md
# SDRAM Command Legality Checker

This block watches the command pins of a four-bank, 16-bit SDRAM and checks every sampled command against the device's sequencing rules. On each rising clock it decodes the command, compares it with the tracked state of the banks, and either accepts it or rejects it. An accepted command updates the bank state. A rejected command leaves all state untouched and is reported one cycle later as an error pulse that carries a code naming the broken rule. The block also derives two data-path qualifiers from the mask pin. One masks incoming write data on the same edge. The other drives the read output enable, which the mask blanks two edges later.

Each bank runs its own state machine with four states. B_IDLE (precharged) moves to B_ACTIVE on an activate. B_ACTIVE moves to B_BURST on a read or write without auto precharge, to B_BURST_AP on one with auto precharge, and back to B_IDLE on a precharge. B_BURST returns to B_ACTIVE when the burst finishes, when a burst stop arrives, or when a read or write to another bank cuts the burst short. A read or write to the same bank restarts B_BURST or moves it to B_BURST_AP. B_BURST_AP moves to B_IDLE when the burst finishes or is stopped. A precharge takes any state to B_IDLE. A shared burst tracker counts the beats of the one burst on the data bus. A small blackout counter runs after a mode register set.

The checker is placed beside a memory controller in simulation or in silicon. It does not drive the memory.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: `cmd_n` = {chip select, row strobe, column strobe, write enable}, all active low. 0000 is mode set, 0001 is refresh, 0010 is precharge, 0011 is activate, 0100 is write, 0101 is read, 0110 is burst stop, 0111 is no-op, and chip select high is deselect. `bank_sel` = {BA1,BA0} selects bank A with 00, B with 10, C with 01 and D with 11. A read or write to a bank in B_IDLE is rejected with code 5.
- R2: An activate to a bank that is not in B_IDLE is rejected with code 6.
- R3: A mode set while any bank is not in B_IDLE is rejected with code 1.
- R4: On the two edges after an accepted mode set, any command other than no-op or deselect is rejected with code 2. The third edge is unrestricted.
- R5: An auto refresh (refresh with `clk_en` high), or a self-refresh entry (refresh with `clk_en` low while it was high on the previous edge), is rejected with code 3 unless every bank is in B_IDLE.
- R6: A read or write with `addr_ap` high runs an auto-precharge burst of BURST_LEN beats. Any read or write on the BURST_LEN-1 edges that follow it is rejected with code 4. After the last beat, the bank is in B_IDLE.
- R7: A precharge with `addr_ap` high closes every bank whatever `bank_sel` holds. With `addr_ap` low it closes only the selected bank.
- R8: A burst stop is accepted at any time and ends the current burst. An auto-precharge burst that is stopped leaves its bank in B_IDLE, and no further write beats follow.
- R9: `wr_mask` equals `mask_in` on each edge that carries a write beat: the edge of the write command and the following BURST_LEN-1 edges, unless the burst is cut short. On all other edges it is 0.
- R10: After edge m, `rd_oe` is 1 exactly when edge m-CAS_LAT carried a read beat and `mask_in` was low at edge m-2.
- R11: `err_valid` and `err_code` are registered. They show the result of the command sampled on the previous edge for one cycle and read 0/0 after a legal command. A rejected command changes no bank state.
- R12: When `clk_en` was low on the previous edge, the sampled command is ignored and raises no error.
- R13: After reset all banks are in B_IDLE, no burst runs, and `err_valid`, `err_code`, `wr_mask` and `rd_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Clock enable line of the memory |
| cmd_n | input | 4 | {chip select, row strobe, column strobe, write enable}, active low |
| mask_in | input | 1 | Data mask line |
| bank_sel | input | 2 | Bank address {BA1,BA0} |
| addr_ap | input | 1 | Address line for auto precharge and precharge-all |
| err_valid | output | 1 | A rule was broken on the previous edge |
| err_code | output | 3 | Which rule was broken (1 to 6); 0 when none |
| wr_mask | output | 1 | Mask for the write data on the current edge |
| rd_oe | output | 1 | Read data output enable |

## Verification
Every internal mistake shows up as a wrong or missing error code one cycle after the first command whose legality depends on it. A bank left open in error shows up as code 6 on the next activate to it, or as code 1 or 3 on the next mode set or refresh. A bank closed in error shows up as code 5 on the next read or write to it. A wrong burst count moves the window in which code 4 appears and shifts the edges on which `wr_mask` and `rd_oe` follow the mask. So the bench places commands right at the edges of each window and probes with a read or write right after each discarded command.

// File: rtl/sdcm_pkg.sv
package sdcm_pkg;

    typedef enum logic [3:0] {
        C_NOP, C_DESEL, C_HOLD, C_MRS, C_AREF, C_SREF,
        C_PRE, C_ACT, C_WR, C_RD, C_BST
    } cmd_e;

    typedef enum logic [1:0] {
        B_IDLE, B_ACTIVE, B_BURST, B_BURST_AP
    } bank_st_e;

    typedef enum logic [2:0] {
        E_NONE      = 3'd0,
        E_MRS_BUSY  = 3'd1,
        E_MRS_GAP   = 3'd2,
        E_REF_BUSY  = 3'd3,
        E_AP_BURST  = 3'd4,
        E_BANK_IDLE = 3'd5,
        E_BANK_OPEN = 3'd6
    } err_e;

endpackage

// File: rtl/sdcm_cmd_decode.sv
module sdcm_cmd_decode
    import sdcm_pkg::*;
(
    input  logic       cke_prev,
    input  logic       cke_now,
    input  logic [3:0] cmd_n,
    output cmd_e       cmd
);
    always_comb begin
        if (!cke_prev) begin
            cmd = C_HOLD;
        end else if (cmd_n[3]) begin
            cmd = C_DESEL;
        end else begin
            unique case (cmd_n[2:0])
                3'b000:  cmd = C_MRS;
                3'b001:  cmd = cke_now ? C_AREF : C_SREF;
                3'b010:  cmd = C_PRE;
                3'b011:  cmd = C_ACT;
                3'b100:  cmd = C_WR;
                3'b101:  cmd = C_RD;
                3'b110:  cmd = C_BST;
                default: cmd = C_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdcm_bank_fsm.sv
module sdcm_bank_fsm
    import sdcm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     go_act,
    input  logic     go_rw,
    input  logic     rw_ap,
    input  logic     go_pre,
    input  logic     go_fin,
    output bank_st_e state
);
    bank_st_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= B_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            B_IDLE:     if (go_act) nxt = B_ACTIVE;
            B_ACTIVE:   if (go_pre) nxt = B_IDLE;
                        else if (go_rw) nxt = rw_ap ? B_BURST_AP : B_BURST;
            B_BURST:    if (go_pre) nxt = B_IDLE;
                        else if (go_rw) nxt = rw_ap ? B_BURST_AP : B_BURST;
                        else if (go_fin) nxt = B_ACTIVE;
            B_BURST_AP: if (go_pre || go_fin) nxt = B_IDLE;
            default:    nxt = B_IDLE;
        endcase
    end

    // R2: the rule checker only opens a bank that is precharged
    a_r2_act_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go_act |-> state == B_IDLE);

    // R6: no new burst may land on a bank in an auto-precharge burst
    a_r6_no_rw_in_ap: assert property (@(posedge clk) disable iff (!rst_n)
        state == B_BURST_AP |-> !go_rw);
endmodule

// File: rtl/sdcm_dqm_pipe.sv
module sdcm_dqm_pipe #(
    parameter int CAS_LAT     = 2,
    parameter int RD_MASK_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mask_in,
    input  logic beat_wr,
    input  logic beat_rd,
    output logic wr_mask,
    output logic rd_oe
);
    logic [CAS_LAT:0]     beat_sr;
    logic [RD_MASK_LAT:0] msk_sr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_sr <= '0;
            msk_sr  <= '0;
        end else begin
            beat_sr <= {beat_sr[CAS_LAT-1:0], beat_rd};
            msk_sr  <= {msk_sr[RD_MASK_LAT-1:0], mask_in};
        end
    end

    assign wr_mask = mask_in & beat_wr;
    assign rd_oe   = beat_sr[CAS_LAT] & ~msk_sr[RD_MASK_LAT];
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdcm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 2,
    parameter int MRS_GAP   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_en,
    input  logic [3:0] cmd_n,
    input  logic       mask_in,
    input  logic [1:0] bank_sel,
    input  logic       addr_ap,
    output logic       err_valid,
    output logic [2:0] err_code,
    output logic       wr_mask,
    output logic       rd_oe
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int CNT_W  = $clog2(BURST_LEN);
    localparam int GAP_W  = $clog2(MRS_GAP + 1);

    cmd_e              cmd;
    err_e              code_now;
    bank_st_e          st [NUM_BANKS];
    logic              cke_q;
    logic [BANK_W-1:0] sel;
    logic [GAP_W-1:0]  gap_cnt;
    logic [CNT_W-1:0]  burst_cnt;
    logic              burst_wr, burst_ap;
    logic [BANK_W-1:0] burst_bank;
    logic              burst_on, all_idle, ok;
    logic              act_ok, rw_ok, wr_ok, rd_ok, pre_ok, bst_ok, mrs_ok;
    logic              pre_hits, cut, fin_any, beat_wr, beat_rd;
    logic [NUM_BANKS-1:0] go_act, go_rw, go_pre, go_fin, in_use, in_burst;

    sdcm_cmd_decode u_dec (
        .cke_prev (cke_q),
        .cke_now  (clk_en),
        .cmd_n    (cmd_n),
        .cmd      (cmd)
    );

    // {BA1,BA0}: 00->A, 10->B, 01->C, 11->D, so the index is the bit-reversed field
    always_comb begin
        for (int i = 0; i < BANK_W; i++) sel[i] = bank_sel[BANK_W-1-i];
    end

    always_comb begin
        all_idle = 1'b1;
        for (int b = 0; b < NUM_BANKS; b++)
            if (st[b] != B_IDLE) all_idle = 1'b0;
    end

    assign burst_on = (burst_cnt != '0);

    always_comb begin
        code_now = E_NONE;
        if (gap_cnt != '0 && !(cmd inside {C_NOP, C_DESEL, C_HOLD})) begin
            code_now = E_MRS_GAP;
        end else begin
            unique case (cmd)
                C_MRS:         if (!all_idle) code_now = E_MRS_BUSY;
                C_AREF, C_SREF: if (!all_idle) code_now = E_REF_BUSY;
                C_ACT:         if (st[sel] != B_IDLE) code_now = E_BANK_OPEN;
                C_RD, C_WR: begin
                    if (burst_on && burst_ap)  code_now = E_AP_BURST;
                    else if (st[sel] == B_IDLE) code_now = E_BANK_IDLE;
                end
                default:       code_now = E_NONE;
            endcase
        end
    end

    assign ok       = (code_now == E_NONE);
    assign act_ok   = ok && cmd == C_ACT;
    assign wr_ok    = ok && cmd == C_WR;
    assign rd_ok    = ok && cmd == C_RD;
    assign rw_ok    = wr_ok || rd_ok;
    assign pre_ok   = ok && cmd == C_PRE;
    assign bst_ok   = ok && cmd == C_BST;
    assign mrs_ok   = ok && cmd == C_MRS;
    assign pre_hits = pre_ok && burst_on && (addr_ap || sel == burst_bank);
    assign cut      = bst_ok || rw_ok || pre_hits;
    assign fin_any  = burst_on && (cut || burst_cnt == CNT_W'(1));
    assign beat_wr  = wr_ok || (burst_on && burst_wr && !cut);
    assign beat_rd  = rd_ok || (burst_on && !burst_wr && !cut);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign go_act[g]   = act_ok && sel == BANK_W'(g);
        assign go_rw[g]    = rw_ok && sel == BANK_W'(g);
        assign go_pre[g]   = pre_ok && (addr_ap || sel == BANK_W'(g));
        assign go_fin[g]   = fin_any && burst_bank == BANK_W'(g);
        assign in_use[g]   = (st[g] != B_IDLE);
        assign in_burst[g] = (st[g] == B_BURST) || (st[g] == B_BURST_AP);

        sdcm_bank_fsm u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .go_act (go_act[g]),
            .go_rw  (go_rw[g]),
            .rw_ap  (addr_ap),
            .go_pre (go_pre[g]),
            .go_fin (go_fin[g]),
            .state  (st[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q      <= 1'b1;
            gap_cnt    <= '0;
            burst_cnt  <= '0;
            burst_wr   <= 1'b0;
            burst_ap   <= 1'b0;
            burst_bank <= '0;
            err_valid  <= 1'b0;
            err_code   <= E_NONE;
        end else begin
            cke_q     <= clk_en;
            err_valid <= !ok;
            err_code  <= code_now;
            if (mrs_ok)               gap_cnt <= GAP_W'(MRS_GAP);
            else if (gap_cnt != '0)   gap_cnt <= gap_cnt - 1'b1;
            if (rw_ok) begin
                burst_cnt  <= CNT_W'(BURST_LEN - 1);
                burst_wr   <= wr_ok;
                burst_ap   <= addr_ap;
                burst_bank <= sel;
            end else if (cut) begin
                burst_cnt  <= '0;
            end else if (burst_on) begin
                burst_cnt  <= burst_cnt - 1'b1;
            end
        end
    end

    sdcm_dqm_pipe #(.CAS_LAT(CAS_LAT), .RD_MASK_LAT(2)) u_dqm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_in (mask_in),
        .beat_wr (beat_wr),
        .beat_rd (beat_rd),
        .wr_mask (wr_mask),
        .rd_oe   (rd_oe)
    );

    // R8: the data bus carries at most one burst at a time
    a_r8_one_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_burst));

    // R7: a precharge-all leaves no bank open
    a_r7_pre_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_ok && addr_ap) |=> (in_use == '0));

    // R11: a reported error always names its rule
    a_r11_valid_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> err_code != 3'd0);

    // R4: nothing but a quiet command is accepted right after a mode set
    a_r4_gap_after_mrs: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mrs_ok) |-> (act_ok == 1'b0 && rw_ok == 1'b0 && pre_ok == 1'b0));
endmodule

// File: tb/tb_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module tb_sdram_cmd_monitor;
    localparam logic [3:0] CMRS = 4'b0000, CREF = 4'b0001, CPRE = 4'b0010,
                           CACT = 4'b0011, CWR  = 4'b0100, CRD  = 4'b0101,
                           CBST = 4'b0110, CNOP = 4'b0111, CDES = 4'b1111;
    localparam logic [1:0] BA_A = 2'b00, BA_B = 2'b10, BA_C = 2'b01, BA_D = 2'b11;

    logic       clk = 1'b0, rst_n = 1'b0, clk_en = 1'b1;
    logic [3:0] cmd_n = CDES;
    logic       mask_in = 1'b0, addr_ap = 1'b0;
    logic [1:0] bank_sel = 2'b00;
    logic       err_valid, wr_mask, rd_oe;
    logic [2:0] err_code;

    typedef struct { int err; int mask; int oe; string req; } exp_t;
    exp_t q[$];
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sdram_cmd_monitor dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cmd_n(cmd_n),
        .mask_in(mask_in), .bank_sel(bank_sel), .addr_ap(addr_ap),
        .err_valid(err_valid), .err_code(err_code), .wr_mask(wr_mask), .rd_oe(rd_oe)
    );

    task automatic check(input bit good, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // driver: one command per edge, expected outcome pushed to the scoreboard
    task automatic opx(input logic [3:0] c, input logic [1:0] bk, input logic ap,
                       input logic m, input logic ce, input int e_err,
                       input int e_mask, input int e_oe, input string req);
        exp_t it;
        @(negedge clk);
        cmd_n = c; bank_sel = bk; addr_ap = ap; mask_in = m; clk_en = ce;
        it.err = e_err; it.mask = e_mask; it.oe = e_oe; it.req = req;
        q.push_back(it);
    endtask

    task automatic op(input logic [3:0] c, input logic [1:0] bk, input logic ap,
                      input int e_err, input string req);
        opx(c, bk, ap, 1'b0, 1'b1, e_err, -1, -1, req);
    endtask

    // monitor: mask before the edge, registered outputs after it
    initial begin
        exp_t it;
        logic mk;
        forever begin
            @(negedge clk);
            #1;
            if (q.size() != 0) begin
                it = q.pop_front();
                mk = wr_mask;
                @(posedge clk);
                #1;
                if (it.err >= 0) begin
                    check(err_valid == (it.err != 0), it.req, "err_valid",
                          int'(err_valid), int'(it.err != 0));
                    check(int'(err_code) == it.err, it.req, "err_code",
                          int'(err_code), it.err);
                end
                if (it.mask >= 0)
                    check(int'(mk) == it.mask, it.req, "wr_mask", int'(mk), it.mask);
                if (it.oe >= 0)
                    check(int'(rd_oe) == it.oe, it.req, "rd_oe", int'(rd_oe), it.oe);
            end
        end
    end

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(err_valid == 1'b0, "R13", "reset err_valid", int'(err_valid), 0);
        check(rd_oe == 1'b0, "R13", "reset rd_oe", int'(rd_oe), 0);
        rst_n = 1'b1;
        opx(CNOP, BA_A, 0, 1, 1, 0, 0, 0, "R13");

        // R1 bank decode and reads/writes to closed banks
        op(CRD,  BA_A, 0, 5, "R1");
        op(CWR,  BA_D, 0, 5, "R1");
        op(CACT, BA_B, 0, 0, "R1");
        op(CRD,  BA_C, 0, 5, "R1");
        op(CRD,  BA_B, 0, 0, "R1");
        repeat (3) op(CNOP, BA_A, 0, 0, "R1");
        // R2 reopen an open bank
        op(CACT, BA_B, 0, 6, "R2");
        // R3 mode set with a bank open, then close it
        op(CMRS, BA_A, 0, 1, "R3");
        op(CPRE, BA_B, 0, 0, "R7");
        // R7 precharge all versus single
        op(CACT, BA_A, 0, 0, "R7");
        op(CACT, BA_D, 0, 0, "R7");
        op(CPRE, BA_C, 1, 0, "R7");
        op(CRD,  BA_A, 0, 5, "R7");
        op(CRD,  BA_D, 0, 5, "R7");
        op(CACT, BA_A, 0, 0, "R7");
        op(CACT, BA_C, 0, 0, "R7");
        op(CPRE, BA_C, 0, 0, "R7");
        op(CRD,  BA_A, 0, 0, "R7");
        op(CRD,  BA_C, 0, 5, "R7");
        repeat (4) op(CNOP, BA_A, 0, 0, "R7");
        op(CPRE, BA_A, 1, 0, "R7");
        // R4 blackout after mode set; R11 discarded command
        op(CMRS, BA_A, 0, 0, "R4");
        op(CACT, BA_A, 0, 2, "R4");
        op(CDES, BA_A, 0, 0, "R4");
        op(CRD,  BA_A, 0, 5, "R11");
        op(CMRS, BA_A, 0, 0, "R4");
        op(CNOP, BA_A, 0, 0, "R4");
        op(CPRE, BA_A, 1, 2, "R4");
        op(CNOP, BA_A, 0, 0, "R4");
        op(CACT, BA_A, 0, 0, "R4");
        // R5 refresh preconditions, R12 ignored commands
        op(CREF, BA_A, 0, 3, "R5");
        opx(CREF, BA_A, 0, 0, 0, 3, -1, -1, "R5");
        op(CRD,  BA_D, 0, 0, "R12");
        op(CNOP, BA_A, 0, 0, "R12");
        op(CPRE, BA_A, 1, 0, "R5");
        op(CREF, BA_A, 0, 0, "R5");
        opx(CREF, BA_A, 0, 0, 0, 0, -1, -1, "R5");
        opx(CACT, BA_B, 0, 0, 0, 0, -1, -1, "R12");
        op(CNOP, BA_A, 0, 0, "R12");
        op(CNOP, BA_A, 0, 0, "R12");
        op(CRD,  BA_B, 0, 5, "R12");
        // R6 auto-precharge burst blocks new bursts
        op(CACT, BA_A, 0, 0, "R6");
        op(CACT, BA_D, 0, 0, "R6");
        op(CWR,  BA_A, 1, 0, "R6");
        op(CRD,  BA_D, 0, 4, "R6");
        op(CWR,  BA_A, 0, 4, "R6");
        op(CRD,  BA_D, 0, 4, "R6");
        op(CRD,  BA_D, 0, 0, "R6");
        op(CRD,  BA_A, 0, 5, "R6");
        repeat (3) op(CNOP, BA_A, 0, 0, "R6");
        // R8 burst stop on an auto-precharge burst and on a write
        op(CACT, BA_A, 0, 0, "R8");
        op(CRD,  BA_A, 1, 0, "R8");
        op(CBST, BA_A, 0, 0, "R8");
        op(CRD,  BA_D, 0, 0, "R8");
        op(CWR,  BA_A, 0, 5, "R8");
        opx(CWR,  BA_D, 0, 1, 1, 0, 1, -1, "R8");
        opx(CBST, BA_A, 0, 1, 1, 0, 0, -1, "R8");
        opx(CNOP, BA_A, 0, 1, 1, 0, 0, -1, "R8");
        // R9 zero-latency write mask
        repeat (4) op(CNOP, BA_A, 0, 0, "R9");
        opx(CWR,  BA_D, 0, 0, 1, 0, 0, -1, "R9");
        opx(CNOP, BA_A, 0, 1, 1, 0, 1, -1, "R9");
        opx(CNOP, BA_A, 0, 0, 1, 0, 0, -1, "R9");
        opx(CNOP, BA_A, 0, 1, 1, 0, 1, -1, "R9");
        opx(CNOP, BA_A, 0, 1, 1, 0, 0, -1, "R9");
        repeat (2) op(CNOP, BA_A, 0, 0, "R10");
        // R10 read output enable with two-edge mask latency
        opx(CRD,  BA_D, 0, 0, 1, 0, 0, 0, "R10");
        opx(CNOP, BA_A, 0, 1, 1, 0, 0, 0, "R10");
        opx(CNOP, BA_A, 0, 0, 1, 0, 0, 1, "R10");
        opx(CNOP, BA_A, 0, 0, 1, 0, 0, 0, "R10");
        opx(CNOP, BA_A, 0, 0, 1, 0, 0, 1, "R10");
        opx(CNOP, BA_A, 0, 0, 1, 0, 0, 1, "R10");
        opx(CNOP, BA_A, 0, 0, 1, 0, 0, 0, "R10");

        wait (q.size() == 0);
        repeat (3) @(posedge clk);
        summary();
    end
endmodule